// File: doc/BRIEF.md
# Interlocked Asynchronous Bus Master Cycle Controller

This block carries out single data transfers as the master of a multi-drop backplane bus. The bus has no clock and uses a fully interlocked handshake. A local requester presents an 18-bit address, a 2-bit cycle type and 16 bits of write data, and pulses a start strobe. The controller then places the address, the type and, for writes, the data on the bus. After a settling interval it raises the master strobe and waits for the slave's acknowledge strobe. When the acknowledge arrives it waits a further settling interval, samples read data if the cycle is a read, and withdraws its strobe and any write data. It then waits for the slave to withdraw the acknowledge before it frees the address and type lines and reports completion. If no acknowledge comes within a set number of clocks, the controller abandons the cycle and reports a timeout.

Every bus line is open-collector and active-low. For each line group the block has a pull output and, where the line is read, a level input. A pull bit of 1 drives the line low, which means the line is asserted and carries a logical 1. The inside of the block works in positive logic and inverts only at the sensed inputs. Bus ownership is taken as already granted when a request arrives. The acknowledge input is asynchronous and passes through a two-stage synchronizer. All delays are parameters counted in clock cycles.

Top module: `abm_master`

## Requirements
- R1: While reset is active and after it is released, every pull output is 0, and `busy`, `done` and `timeout` are 0.
- R2: After a start is accepted, the address and type pulls are driven for exactly SETUP_CYC clock cycles before the master strobe pull rises (`busy`=1 and strobe=0 for SETUP_CYC cycles). The type pull carries the requested code, with bit 1 as the high control line.
- R3: Polarity: a pull bit of 1 means the line is asserted (driven low, logical 1). Read data is the bitwise inverse of the sensed data levels, and a sensed acknowledge level of 0 means asserted.
- R4: Plain read (type 00): after the acknowledge level goes low, the master strobe pull falls on the (SAMPLE_CYC+3)th clock edge. This counts the two synchronizer stages and the state machine. `rd_data` then holds the inverted data levels sampled at that edge.
- R5: Word write (type 10): all 16 data pulls carry `req_wdata` from the start of setup until the strobe falls. They stay unchanged during that time and drop to 0 on the same edge as the strobe.
- R6: Byte write (type 11): the low byte of `req_wdata` is driven on data bits 7:0 when address bit 0 is 0, and on bits 15:8 when it is 1. The other byte's pulls stay 0.
- R7: Read with write to follow (type 01) is handled like a plain read: the data pulls stay 0 and the read data is captured.
- R8: After the strobe falls, the address and type pulls stay driven and no new strobe is raised while the acknowledge is still asserted. On the third clock edge after the acknowledge level returns high, `busy` falls, all pulls are 0 and `done` pulses for one cycle with `timeout`=0.
- R9: If no acknowledge arrives within TMO_CYC cycles of the strobe rising, the strobe is held for exactly TMO_CYC cycles and then, on one edge, all pulls drop to 0 and `done` and `timeout` pulse together.
- R10: A start is ignored while a cycle is in progress, and also while the synchronized acknowledge is asserted with the controller idle. In both cases the bus pins do not change and no further cycle begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_start | input | 1 | One-cycle request strobe |
| req_type | input | 2 | Cycle type: 00 read, 01 read with write to follow, 10 word write, 11 byte write |
| req_addr | input | 18 | Bus address |
| req_wdata | input | 16 | Write data (low byte used for byte writes) |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | With `done`, marks an abandoned cycle |
| rd_data | output | 16 | Captured read data |
| bus_addr_pull | output | 18 | 1 = pull address line low (asserted) |
| bus_ctl_pull | output | 2 | 1 = pull control line low; bit 1 is the high control line |
| bus_data_pull | output | 16 | 1 = pull data line low |
| bus_msyn_pull | output | 1 | 1 = pull the master strobe low |
| bus_ssyn_lvl | input | 1 | Sensed acknowledge level (0 = asserted) |
| bus_data_lvl | input | 16 | Sensed data levels (0 = logical 1) |

## Verification
The hardest situation to reach is the tail of the handshake. Here the strobe has already been withdrawn, but the slave still holds its acknowledge, and the controller must keep the address driven without raising a new strobe. A reactive slave model in the bench creates this state: it holds the acknowledge for a chosen number of cycles after it sees the strobe fall and checks the pins on every cycle of that hold. The bench also forces the acknowledge low while the controller is idle and then offers a start, and it pulses start in the middle of a running cycle. Together these reach the two cases in which a start must be dropped.

// File: rtl/abm_pkg.sv
package abm_pkg;
  localparam logic [1:0] CYC_RD  = 2'b00;
  localparam logic [1:0] CYC_RDW = 2'b01;
  localparam logic [1:0] CYC_WRW = 2'b10;
  localparam logic [1:0] CYC_WRB = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT,
    ST_SAMPLE,
    ST_REL
  } abm_state_e;
endpackage

// File: rtl/abm_sync.sv
module abm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/abm_timer.sv
module abm_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (clr)              cnt_d = '0;
    else if (cnt != '1)   cnt_d = cnt + 1'b1;
    else                  cnt_d = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/abm_lane.sv
module abm_lane #(
  parameter int DW    = 16,
  parameter int LW    = 8,
  parameter int LANES = DW / LW,
  parameter int SW    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [DW-1:0] wdata,
  input  logic          byte_mode,
  input  logic [SW-1:0] lane_sel,
  output logic [DW-1:0] pattern
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign pattern[i*LW +: LW] = byte_mode
      ? ((lane_sel == SW'(i)) ? wdata[LW-1:0] : '0)
      : wdata[i*LW +: LW];
  end
endmodule

// File: rtl/abm_master.sv
module abm_master
  import abm_pkg::*;
#(
  parameter int AW         = 18,
  parameter int DW         = 16,
  parameter int SETUP_CYC  = 38,
  parameter int SAMPLE_CYC = 19,
  parameter int TMO_CYC    = 2500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_start,
  input  logic [1:0]    req_type,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic          timeout,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] bus_addr_pull,
  output logic [1:0]    bus_ctl_pull,
  output logic [DW-1:0] bus_data_pull,
  output logic          bus_msyn_pull,
  input  logic          bus_ssyn_lvl,
  input  logic [DW-1:0] bus_data_lvl
);
  localparam int LW    = 8;
  localparam int LANES = DW / LW;
  localparam int SW    = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int MAX1  = (SETUP_CYC > SAMPLE_CYC) ? SETUP_CYC : SAMPLE_CYC;
  localparam int MAXC  = (MAX1 > TMO_CYC) ? MAX1 : TMO_CYC;
  localparam int CW    = $clog2(MAXC + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // acknowledge: invert at the pin, then synchronize
  logic ssyn_s;
  abm_sync #(.STAGES(2)) u_ssyn_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (~bus_ssyn_lvl),
    .q     (ssyn_s)
  );

  // write data steered onto byte lanes
  logic [DW-1:0] wpat;
  abm_lane #(.DW(DW), .LW(LW), .LANES(LANES), .SW(SW)) u_lane (
    .wdata     (req_wdata),
    .byte_mode (req_type == CYC_WRB),
    .lane_sel  (req_addr[SW-1:0]),
    .pattern   (wpat)
  );

  abm_state_e    state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [1:0]    type_q;
  logic [DW-1:0] wpat_q;
  logic [DW-1:0] rdata_q;
  logic          ac_q, ac_d;
  logic          dd_q, dd_d;
  logic          msyn_q, msyn_d;
  logic          done_q, done_d;
  logic          tmo_q, tmo_d;
  logic          load_en;
  logic          cap_en;
  logic          tmr_clr;
  logic [CW-1:0] cnt;

  abm_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (tmr_clr),
    .cnt   (cnt)
  );

  logic hit_setup, hit_sample, hit_tmo;
  assign hit_setup  = (cnt == CW'(SETUP_CYC - 1));
  assign hit_sample = (cnt == CW'(SAMPLE_CYC - 1));
  assign hit_tmo    = (cnt == CW'(TMO_CYC - 1));

  // next-state logic
  always_comb begin
    state_d = state_q;
    ac_d    = ac_q;
    dd_d    = dd_q;
    msyn_d  = msyn_q;
    done_d  = 1'b0;
    tmo_d   = 1'b0;
    load_en = 1'b0;
    cap_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_start && !ssyn_s) begin
          load_en = 1'b1;
          ac_d    = 1'b1;
          dd_d    = req_type[1];
          state_d = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (hit_setup) begin
          msyn_d  = 1'b1;
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (ssyn_s) begin
          state_d = ST_SAMPLE;
        end else if (hit_tmo) begin
          msyn_d  = 1'b0;
          ac_d    = 1'b0;
          dd_d    = 1'b0;
          done_d  = 1'b1;
          tmo_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_SAMPLE: begin
        if (hit_sample) begin
          cap_en  = ~type_q[1];
          msyn_d  = 1'b0;
          dd_d    = 1'b0;
          state_d = ST_REL;
        end
      end
      ST_REL: begin
        if (!ssyn_s) begin
          ac_d    = 1'b0;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    tmr_clr = (state_q == ST_IDLE) || (state_d != state_q);
  end

  // state and control registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      ac_q    <= 1'b0;
      dd_q    <= 1'b0;
      msyn_q  <= 1'b0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ac_q    <= ac_d;
      dd_q    <= dd_d;
      msyn_q  <= msyn_d;
      done_q  <= done_d;
      tmo_q   <= tmo_d;
    end
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q <= '0;
      type_q <= CYC_RD;
      wpat_q <= '0;
    end else if (load_en) begin
      addr_q <= req_addr;
      type_q <= req_type;
      wpat_q <= wpat;
    end
  end

  // read data capture, enabled at the sample point
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdata_q <= '0;
    else if (cap_en) rdata_q <= ~bus_data_lvl;
  end

  assign busy          = (state_q != ST_IDLE);
  assign done          = done_q;
  assign timeout       = tmo_q;
  assign rd_data       = rdata_q;
  assign bus_addr_pull = addr_q & {AW{ac_q}};
  assign bus_ctl_pull  = type_q & {2{ac_q}};
  assign bus_data_pull = wpat_q & {DW{dd_q}};
  assign bus_msyn_pull = msyn_q;

  // R2: strobe rises only after address/type were already on the bus
  a_r2_setup_before_strobe: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(msyn_q) |-> $past(ac_q) && $past(state_q) == ST_SETUP);

  // R8: strobe is never driven without address and type
  a_r8_strobe_needs_addr: assert property (@(posedge clk) disable iff (!rst_int_n)
    msyn_q |-> ac_q);

  // R5: data pulls are only used by write types
  a_r5_data_only_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    dd_q |-> type_q[1]);

  // R5: write data leaves the bus no later than the strobe
  a_r5_data_drops_with_strobe: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(msyn_q) |-> !dd_q);

  // R8: a normal completion happens only with the acknowledge withdrawn
  a_r8_done_after_ack_clear: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_q && !tmo_q) |-> (!ssyn_s && !ac_q && !msyn_q));

  // R9: a timeout frees every line in the same cycle it is reported
  a_r9_timeout_frees_bus: assert property (@(posedge clk) disable iff (!rst_int_n)
    tmo_q |-> (done_q && !msyn_q && !ac_q && !dd_q));

  // R10: a start during a cycle does not disturb the captured address
  a_r10_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q != ST_IDLE && req_start) |=> $stable(addr_q) && $stable(type_q));
endmodule

// File: tb/abm_master_tb.sv
`timescale 1ns/1ps
module abm_master_tb;
  localparam int AW  = 18;
  localparam int DW  = 16;
  localparam int SU  = 38;
  localparam int SMP = 19;
  localparam int TMO = 200;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_start = 1'b0;
  logic [1:0]    req_type = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          busy, done, timeout;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] bus_addr_pull;
  logic [1:0]    bus_ctl_pull;
  logic [DW-1:0] bus_data_pull;
  logic          bus_msyn_pull;
  logic          bus_ssyn_lvl = 1'b1;
  logic [DW-1:0] bus_data_lvl = '1;

  always #2 clk = ~clk;

  abm_master #(.AW(AW), .DW(DW), .SETUP_CYC(SU), .SAMPLE_CYC(SMP), .TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_type(req_type),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .timeout(timeout), .rd_data(rd_data), .bus_addr_pull(bus_addr_pull),
    .bus_ctl_pull(bus_ctl_pull), .bus_data_pull(bus_data_pull),
    .bus_msyn_pull(bus_msyn_pull), .bus_ssyn_lvl(bus_ssyn_lvl),
    .bus_data_lvl(bus_data_lvl)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_pat(input logic [17:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  typedef struct packed {
    logic [1:0]  ty;
    logic [17:0] a;
    logic [15:0] dpat;
    logic [15:0] rd;
    logic        tmo;
  } exp_t;

  exp_t exp_q[$];

  // slave behaviour controls
  bit  sl_silent = 1'b0;
  int  sl_rdly   = 3;
  int  sl_hdly   = 2;
  logic [17:0] seen_addr;
  logic [1:0]  seen_ctl;
  logic [15:0] seen_data;

  // reactive slave model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && busy) begin
        int su;
        su = 0;
        while (busy && !bus_msyn_pull) begin su++; @(negedge clk); end
        chk(su == SU, "R2 setup cycles before strobe", su, SU);
        seen_addr = bus_addr_pull;
        seen_ctl  = bus_ctl_pull;
        seen_data = bus_data_pull;
        if (sl_silent) begin
          int m;
          m = 0;
          while (bus_msyn_pull) begin m++; @(negedge clk); end
          chk(m == TMO, "R9 strobe length before timeout", m, TMO);
          chk(done && timeout && bus_addr_pull == 0 && bus_ctl_pull == 0 && bus_data_pull == 0,
              "R9 bus freed with done+timeout", {done, timeout, 14'd0, bus_addr_pull[15:0]}, 32'hC000_0000);
        end else begin
          int lat;
          bit stable_ok;
          stable_ok = 1'b1;
          repeat (sl_rdly) begin
            if (bus_data_pull != seen_data || bus_addr_pull != seen_addr) stable_ok = 1'b0;
            @(negedge clk);
          end
          bus_ssyn_lvl = 1'b0;
          if (!seen_ctl[1]) bus_data_lvl = ~rd_pat(seen_addr);
          lat = 0;
          do begin
            if (bus_msyn_pull && bus_data_pull != seen_data) stable_ok = 1'b0;
            @(negedge clk);
            lat++;
          end while (bus_msyn_pull);
          chk(lat == SMP + 3, "R4 ack-to-strobe-release edges", lat, SMP + 3);
          chk(stable_ok, "R5 data/address stable while strobed", stable_ok, 1);
          chk(bus_data_pull == 0, "R5 data released with strobe", bus_data_pull, 0);
          for (int h = 0; h < sl_hdly; h++) begin
            chk(busy && !bus_msyn_pull && !done && bus_addr_pull == seen_addr && bus_ctl_pull == seen_ctl,
                "R8 address held, no new strobe while ack held", bus_addr_pull, seen_addr);
            @(negedge clk);
          end
          bus_ssyn_lvl = 1'b1;
          bus_data_lvl = '1;
          lat = 0;
          do begin @(negedge clk); lat++; end while (busy);
          chk(lat == 3, "R8 release-to-idle edges", lat, 3);
          chk(done && !timeout && bus_addr_pull == 0 && bus_ctl_pull == 0 && !bus_msyn_pull,
              "R8 lines free and done at end", {done, timeout, bus_addr_pull[15:0]}, 32'h2_0000);
        end
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(timeout == e.tmo, "R9 timeout flag", timeout, e.tmo);
          chk(seen_addr == e.a, "R3 address pulls", seen_addr, e.a);
          chk(seen_ctl == e.ty, "R2 control code", seen_ctl, e.ty);
          chk(seen_data == e.dpat, "R6 data lane pattern", seen_data, e.dpat);
          if (!e.tmo && !e.ty[1])
            chk(rd_data == e.rd, "R4 R7 read data (R3 polarity)", rd_data, e.rd);
        end
      end
    end
  end

  task automatic launch(input logic [1:0] ty, input logic [17:0] a, input logic [15:0] wd,
                        input bit silent, input int rdly, input int hdly);
    exp_t e;
    sl_silent = silent;
    sl_rdly   = rdly;
    sl_hdly   = hdly;
    e.ty  = ty;
    e.a   = a;
    e.tmo = silent;
    e.rd  = rd_pat(a);
    case (ty)
      2'b10:   e.dpat = wd;
      2'b11:   e.dpat = a[0] ? {wd[7:0], 8'h00} : {8'h00, wd[7:0]};
      default: e.dpat = 16'h0000;
    endcase
    exp_q.push_back(e);
    @(negedge clk);
    req_type  = ty;
    req_addr  = a;
    req_wdata = wd;
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
    @(negedge clk);
  endtask

  task automatic do_cycle(input logic [1:0] ty, input logic [17:0] a, input logic [15:0] wd,
                          input bit silent, input int rdly, input int hdly);
    launch(ty, a, wd, silent, rdly, hdly);
    wait_idle();
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, got busy=%0d expected end", busy);
    report();
  end

  initial begin
    // R1 reset state
    repeat (4) @(negedge clk);
    chk(bus_addr_pull == 0 && bus_ctl_pull == 0 && bus_data_pull == 0 && !bus_msyn_pull && !busy && !done && !timeout,
        "R1 outputs in reset", {busy, done, timeout, bus_msyn_pull}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(bus_addr_pull == 0 && bus_ctl_pull == 0 && bus_data_pull == 0 && !bus_msyn_pull && !busy && !done,
        "R1 outputs after reset", {busy, done, bus_msyn_pull}, 0);

    do_cycle(2'b00, 18'h0006E, 16'h0000, 1'b0, 3, 2);    // R4 plain read
    do_cycle(2'b01, 18'h3FFFE, 16'hFFFF, 1'b0, 1, 1);    // R7 read, write follows
    do_cycle(2'b10, 18'h000D4, 16'h8000, 1'b0, 2, 3);    // R5 word write
    do_cycle(2'b11, 18'h00100, 16'h12AB, 1'b0, 4, 1);    // R6 even byte lane
    do_cycle(2'b11, 18'h20101, 16'h34CD, 1'b0, 4, 1);    // R6 odd byte lane
    do_cycle(2'b00, 18'h00000, 16'h0000, 1'b0, 50, 10);  // R8 slow slave, long hold
    do_cycle(2'b10, 18'h1F0F0, 16'hFFFF, 1'b1, 0, 0);    // R9 timeout
    do_cycle(2'b00, 18'h0A5A5, 16'h0000, 1'b0, 2, 2);    // recovers after R9

    // R10: start during a running cycle is ignored
    launch(2'b00, 18'h01234, 16'h0000, 1'b0, 30, 2);
    do @(negedge clk); while (!bus_msyn_pull);
    req_type  = 2'b10;
    req_addr  = 18'h15555;
    req_wdata = 16'hBEEF;
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    @(negedge clk);
    chk(bus_addr_pull == 18'h01234 && bus_ctl_pull == 2'b00 && bus_data_pull == 0,
        "R10 pins unchanged by start while busy", bus_addr_pull, 18'h01234);
    wait_idle();
    repeat (4) @(negedge clk);
    chk(!busy && !bus_msyn_pull, "R10 no extra cycle after busy start", busy, 0);

    // R10: start while acknowledge held with controller idle
    bus_ssyn_lvl = 1'b0;
    repeat (4) @(negedge clk);
    req_type  = 2'b00;
    req_addr  = 18'h00777;
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    repeat (5) @(negedge clk);
    chk(!busy && bus_addr_pull == 0 && !bus_msyn_pull, "R10 start ignored with ack asserted", busy, 0);
    bus_ssyn_lvl = 1'b1;
    repeat (4) @(negedge clk);

    // mixed sweep
    for (int k = 0; k < 8; k++) begin
      logic [17:0] a;
      a = 18'(k * 18'h0A3B1 + 18'h00011);
      do_cycle(2'(k), a, 16'(k * 16'h1357 + 16'h0F0F), 1'b0, k + 1, (k % 3) + 1);
    end

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R8 every cycle completed", exp_q.size(), 0);
    report();
  end
endmodule